// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the data-path ALU of a small accumulator-style processor core. Each cycle it can take a 4-bit operation code, the accumulator, the X index register, an operand byte and the current status byte. It computes a result byte and a new status byte, and it reports which register the result is meant for. The flag rules are exact: subtract and compare use an inverted-borrow carry, the bit test copies the operand's top two bits into N and V, and one combined operation subtracts the operand from the AND of A and X and sends the difference to X. Decimal arithmetic, instruction decoding and memory access stay with the surrounding core.

The function is combinational. Its outputs are captured in an output register whenever `valid_i` is high and hold their value otherwise. Status bits other than N, V, Z and C pass from `stat_i` to `stat_o` unchanged. The reset input asserts asynchronously and releases on a clock edge through a two-stage synchronizer, so the output register comes out of reset two rising edges after `rst_n` goes high.

Top module: `alu8_core`

## Requirements
- R1: Op 5 (add with carry) gives res = A + M + C, low 8 bits. C is bit 8 of the 9-bit sum. V is set when A and M have the same sign bit and the result's sign differs from A's. N and Z are updated; destination code 1.
- R2: Op 6 (subtract with borrow) gives res = A − M − (1 − C), low 8 bits. C is 1 when no borrow occurs. V is bit 7 of (A XOR M) AND (A XOR res). N and Z are updated; destination code 1.
- R3: Op 7 compares A with M and op 8 compares X with M. res is the low byte of the difference. C is set when the first value is greater than or equal to M. N and Z come from the difference. V is kept; destination code 0.
- R4: Op 4 (bit test) sets Z when (A AND M) is zero, copies M bit 7 into N and M bit 6 into V, and keeps C. res equals A; destination code 0.
- R5: Op 15 computes (A AND X) − M. It sets N, Z and C as a compare does, keeps V, and outputs the low byte with destination code 3 (X).
- R6: Op 11 shifts M left with bit 7 into C. Op 12 shifts M right with bit 0 into C, so N is always 0. N and Z are updated, V is kept; destination code 2.
- R7: Op 13 rotates M left through C, with the old C entering bit 0. Op 14 rotates M right through C, with the old C entering bit 7. The bit that leaves the byte becomes the new C. V is kept; destination code 2.
- R8: Ops 0 (load M), 1 (AND), 2 (OR), 3 (XOR), 9 (M+1) and 10 (M−1) update only N and Z. C and V are kept. Ops 0–3 use destination code 1; ops 9 and 10 use code 2.
- R9: For every op except 4, Z is 1 exactly when the 8-bit result is zero, and N equals result bit 7.
- R10: Status bit positions are C=0, Z=1, V=6 and N=7. Bits 2, 3, 4 and 5 of `stat_o` equal those bits of `stat_i`.
- R11: Outputs load on a rising edge with `valid_i` high and hold while `valid_i` is low.
- R12: While reset is active, `res_o` and `stat_o` are 0 and `dst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases on a clock edge |
| valid_i | input | 1 | Capture strobe for the output register |
| op_i | input | 4 | Operation code (values listed in R1–R8) |
| acc_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| opnd_i | input | 8 | Operand byte |
| stat_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Registered result byte |
| stat_o | output | 8 | Registered status byte |
| dst_o | output | 2 | Result destination: 0 none, 1 accumulator, 2 modified operand, 3 X |

## Verification
The hardest cases to reach are the signed-overflow corners of subtract-with-borrow. With a borrow coming in, and with operands of opposite sign whose difference wraps past the sign bit, V and C can disagree in ways an add never produces. The vector table sets up these cases by choosing the incoming C and operands of opposite sign directly. It also pairs compare and the combined AND-X operation with V already set, to show that V survives. Other vectors drive the reserved status bits to one, to show they pass through untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_BIT  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_CMPA = 4'd7,
    OP_CMPX = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_ASL  = 4'd11,
    OP_LSR  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_AXS  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_MOD  = 2'd2,
    DST_X    = 2'd3
  } alu_dst_e;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_Z  = 1;
  localparam int unsigned FLG_V  = 6;
  localparam int unsigned FLG_N  = 7;

  // flag values plus per-flag write enables produced by each unit
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
    logic wn;
    logic wv;
    logic wz;
    logic wc;
  } flag_upd_t;

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  output logic [W-1:0]   res,
  output flag_upd_t      fu
);

  logic [W-1:0] masked;

  assign masked = a & m;

  always_comb begin
    unique case (op)
      OP_LOAD: res = m;
      OP_AND:  res = masked;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      default: res = a;   // bit test leaves A as the result
    endcase
  end

  always_comb begin
    fu    = '0;
    fu.wn = 1'b1;
    fu.wz = 1'b1;
    if (op == OP_BIT) begin
      fu.n  = m[W-1];
      fu.v  = m[W-2];
      fu.wv = 1'b1;
      fu.z  = (masked == '0);
    end else begin
      fu.n  = res[W-1];
      fu.z  = (res == '0);
    end
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   m,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output flag_upd_t      fu
);

  localparam int unsigned SW = W + 1;

  logic [W-1:0]  lhs;
  logic [W-1:0]  rhs;
  logic          cin;
  logic [SW-1:0] sum;

  // one adder serves every arithmetic op; subtraction adds the inverted operand
  always_comb begin
    lhs = a;
    rhs = m;
    cin = 1'b0;
    unique case (op)
      OP_ADC:  begin lhs = a;     rhs = m;  cin = c_in; end
      OP_SBC:  begin lhs = a;     rhs = ~m; cin = c_in; end
      OP_CMPA: begin lhs = a;     rhs = ~m; cin = 1'b1; end
      OP_CMPX: begin lhs = x;     rhs = ~m; cin = 1'b1; end
      OP_AXS:  begin lhs = a & x; rhs = ~m; cin = 1'b1; end
      OP_INC:  begin lhs = m;     rhs = '0; cin = 1'b1; end
      OP_DEC:  begin lhs = m;     rhs = '1; cin = 1'b0; end
      default: begin lhs = a;     rhs = m;  cin = 1'b0; end
    endcase
  end

  assign sum = {1'b0, lhs} + {1'b0, rhs} + {{(SW-1){1'b0}}, cin};
  assign res = sum[W-1:0];

  always_comb begin
    fu    = '0;
    fu.n  = res[W-1];
    fu.z  = (res == '0);
    fu.wn = 1'b1;
    fu.wz = 1'b1;
    fu.c  = sum[W];
    fu.v  = ~(lhs[W-1] ^ rhs[W-1]) & (lhs[W-1] ^ res[W-1]);
    fu.wc = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMPA) ||
            (op == OP_CMPX) || (op == OP_AXS);
    fu.wv = (op == OP_ADC) || (op == OP_SBC);
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   m,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output flag_upd_t      fu
);

  logic left;
  logic fill;

  // left-moving ops drop bit W-1, right-moving ops drop bit 0
  assign left = (op == OP_ASL) || (op == OP_ROL);

  always_comb begin
    unique case (op)
      OP_ROL, OP_ROR: fill = c_in;
      default:        fill = 1'b0;
    endcase
  end

  always_comb begin
    if (left) res = {m[W-2:0], fill};
    else      res = {fill, m[W-1:1]};
  end

  always_comb begin
    fu    = '0;
    fu.n  = res[W-1];
    fu.z  = (res == '0);
    fu.c  = left ? m[W-1] : m[0];
    fu.wn = 1'b1;
    fu.wz = 1'b1;
    fu.wc = 1'b1;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [3:0]          op_i,
  input  logic [W-1:0]        acc_i,
  input  logic [W-1:0]        x_i,
  input  logic [W-1:0]        opnd_i,
  input  logic [STAT_W-1:0]   stat_i,
  output logic [W-1:0]        res_o,
  output logic [STAT_W-1:0]   stat_o,
  output logic [1:0]          dst_o
);

  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {GRP_LOGIC, GRP_ARITH, GRP_SHIFT} grp_e;

  alu_op_e op;
  grp_e    grp;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  logic [W-1:0] res_lg, res_ar, res_sh, res_sel;
  flag_upd_t    fu_lg, fu_ar, fu_sh, fu_sel;

  logic [STAT_W-1:0] stat_calc;
  alu_dst_e          dst_calc;

  logic [W-1:0]      res_d,  res_q;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic [1:0]        dst_d,  dst_q;

  assign op = alu_op_e'(op_i);

  // reset asserts at once, releases after SYNC_STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  alu8_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (acc_i),
    .m   (opnd_i),
    .res (res_lg),
    .fu  (fu_lg)
  );

  alu8_arith #(.W(W)) u_arith (
    .op   (op),
    .a    (acc_i),
    .x    (x_i),
    .m    (opnd_i),
    .c_in (stat_i[FLG_C]),
    .res  (res_ar),
    .fu   (fu_ar)
  );

  alu8_shift #(.W(W)) u_shift (
    .op   (op),
    .m    (opnd_i),
    .c_in (stat_i[FLG_C]),
    .res  (res_sh),
    .fu   (fu_sh)
  );

  always_comb begin
    unique case (op)
      OP_LOAD, OP_AND, OP_OR, OP_XOR, OP_BIT: grp = GRP_LOGIC;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR:         grp = GRP_SHIFT;
      default:                                grp = GRP_ARITH;
    endcase
  end

  always_comb begin
    unique case (grp)
      GRP_LOGIC: begin res_sel = res_lg; fu_sel = fu_lg; end
      GRP_SHIFT: begin res_sel = res_sh; fu_sel = fu_sh; end
      default:   begin res_sel = res_ar; fu_sel = fu_ar; end
    endcase
  end

  // merge written flags into the incoming byte; other bits pass through
  always_comb begin
    stat_calc = stat_i;
    if (fu_sel.wn) stat_calc[FLG_N] = fu_sel.n;
    if (fu_sel.wv) stat_calc[FLG_V] = fu_sel.v;
    if (fu_sel.wz) stat_calc[FLG_Z] = fu_sel.z;
    if (fu_sel.wc) stat_calc[FLG_C] = fu_sel.c;
  end

  always_comb begin
    unique case (op)
      OP_BIT, OP_CMPA, OP_CMPX:                                  dst_calc = DST_NONE;
      OP_AXS:                                                    dst_calc = DST_X;
      OP_INC, OP_DEC, OP_ASL, OP_LSR, OP_ROL, OP_ROR:            dst_calc = DST_MOD;
      default:                                                   dst_calc = DST_ACC;
    endcase
  end

  // next-state: capture on strobe, hold otherwise
  always_comb begin
    res_d  = res_q;
    stat_d = stat_q;
    dst_d  = dst_q;
    if (valid_i) begin
      res_d  = res_sel;
      stat_d = stat_calc;
      dst_d  = dst_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      stat_q <= '0;
      dst_q  <= DST_NONE;
    end else begin
      res_q  <= res_d;
      stat_q <= stat_d;
      dst_q  <= dst_d;
    end
  end

  assign res_o  = res_q;
  assign stat_o = stat_q;
  assign dst_o  = dst_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [3:0] op_i,
  input logic [7:0] opnd_i,
  input logic [7:0] stat_i,
  input logic [7:0] res_o,
  input logic [7:0] stat_o,
  input logic [1:0] dst_o
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(res_o) && $stable(stat_o) && $stable(dst_o)));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ((stat_o & 8'h3C) == ($past(stat_i) & 8'h3C)));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 4'd4) |=> (stat_o[1] == (res_o == 8'h00)));

  p_neg_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 4'd4) |=> (stat_o[7] == res_o[7]));

  p_lsr_clear_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd12) |=> !stat_o[7]);

  p_bit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd4) |=>
      (stat_o[7] == $past(opnd_i[7]) && stat_o[6] == $past(opnd_i[6]) && dst_o == 2'd0));

  p_v_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 4'd4 && op_i != 4'd5 && op_i != 4'd6) |=>
      (stat_o[6] == $past(stat_i[6])));

  p_axs_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd15) |=> (dst_o == 2'd3));

endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .valid_i (valid_i),
  .op_i    (op_i),
  .opnd_i  (opnd_i),
  .stat_i  (stat_i),
  .res_o   (res_o),
  .stat_o  (stat_o),
  .dst_o   (dst_o)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 24;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] x;
    logic [7:0] m;
    logic [7:0] s;
    logic [7:0] er;
    logic [7:0] es;
    logic [1:0] ed;
  } vec_t;

  //   op     a      x      m      s_in   res    s_out  dst
  localparam vec_t VECS [NVEC] = '{
    '{4'd5,  8'h50, 8'h00, 8'h50, 8'h00, 8'hA0, 8'hC0, 2'd1},
    '{4'd5,  8'hFF, 8'h00, 8'h01, 8'h25, 8'h01, 8'h25, 2'd1},
    '{4'd5,  8'h80, 8'h00, 8'h80, 8'h00, 8'h00, 8'h43, 2'd1},
    '{4'd6,  8'h50, 8'h00, 8'hF0, 8'h01, 8'h60, 8'h00, 2'd1},
    '{4'd6,  8'h50, 8'h00, 8'hB0, 8'h01, 8'hA0, 8'hC0, 2'd1},
    '{4'd6,  8'h05, 8'h00, 8'h05, 8'h08, 8'hFF, 8'h88, 2'd1},
    '{4'd7,  8'h40, 8'h00, 8'h40, 8'h40, 8'h00, 8'h43, 2'd0},
    '{4'd7,  8'h10, 8'h00, 8'h20, 8'h01, 8'hF0, 8'h80, 2'd0},
    '{4'd8,  8'h00, 8'h30, 8'h10, 8'h00, 8'h20, 8'h01, 2'd0},
    '{4'd4,  8'h0F, 8'h00, 8'hC0, 8'h01, 8'h0F, 8'hC3, 2'd0},
    '{4'd4,  8'h0F, 8'h00, 8'h01, 8'hC0, 8'h0F, 8'h00, 2'd0},
    '{4'd15, 8'hF0, 8'h3C, 8'h10, 8'h40, 8'h20, 8'h41, 2'd3},
    '{4'd15, 8'h0F, 8'h03, 8'h05, 8'h00, 8'hFE, 8'h80, 2'd3},
    '{4'd9,  8'h00, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h03, 2'd2},
    '{4'd10, 8'h00, 8'h00, 8'h00, 8'h40, 8'hFF, 8'hC0, 2'd2},
    '{4'd11, 8'h00, 8'h00, 8'h81, 8'h00, 8'h02, 8'h01, 2'd2},
    '{4'd12, 8'h00, 8'h00, 8'h81, 8'h80, 8'h40, 8'h01, 2'd2},
    '{4'd13, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h01, 2'd2},
    '{4'd14, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h03, 2'd2},
    '{4'd14, 8'h00, 8'h00, 8'h02, 8'h01, 8'h81, 8'h80, 2'd2},
    '{4'd0,  8'h00, 8'h00, 8'h00, 8'hC1, 8'h00, 8'h43, 2'd1},
    '{4'd1,  8'hF0, 8'h00, 8'h8F, 8'h00, 8'h80, 8'h80, 2'd1},
    '{4'd2,  8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h3E, 2'd1},
    '{4'd3,  8'hAA, 8'h00, 8'hAA, 8'hFF, 8'h00, 8'h7F, 2'd1}
  };

  logic       clk;
  logic       rst_n;
  logic       valid_i;
  logic [3:0] op_i;
  logic [7:0] acc_i, x_i, opnd_i, stat_i;
  logic [7:0] res_o, stat_o;
  logic [1:0] dst_o;

  int checks;
  int failures;
  bit done;

  alu8_core u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .x_i     (x_i),
    .opnd_i  (opnd_i),
    .stat_i  (stat_i),
    .res_o   (res_o),
    .stat_o  (stat_o),
    .dst_o   (dst_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd4:         return "R4";
      4'd5:         return "R1";
      4'd6:         return "R2";
      4'd7, 4'd8:   return "R3";
      4'd15:        return "R5";
      4'd11, 4'd12: return "R6";
      4'd13, 4'd14: return "R7";
      default:      return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      finish_run();
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; valid_i = 1'b0; op_i = 4'd0;
    acc_i = 8'h00; x_i = 8'h00; opnd_i = 8'h00; stat_i = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "res", res_o, 8'h00);
    check("R12", "stat", stat_o, 8'h00);
    check("R12", "dst", {6'd0, dst_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      valid_i = 1'b1;
      op_i = VECS[i].op; acc_i = VECS[i].a; x_i = VECS[i].x;
      opnd_i = VECS[i].m; stat_i = VECS[i].s;
      @(negedge clk);
      check(tag_of(VECS[i].op), "res", res_o, VECS[i].er);
      // R9 and R10 also covered by the status comparison
      check(tag_of(VECS[i].op), "stat R9 R10", stat_o, VECS[i].es);
      check(tag_of(VECS[i].op), "dst", {6'd0, dst_o}, {6'd0, VECS[i].ed});
    end

    // R11: strobe low, inputs change, outputs keep last captured values
    valid_i = 1'b0;
    op_i = 4'd5; acc_i = 8'h11; opnd_i = 8'h22; stat_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R11", "res hold", res_o, 8'h00);
    check("R11", "stat hold", stat_o, 8'h7F);
    check("R11", "dst hold", {6'd0, dst_o}, 8'h01);

    // R2 corner: borrow in with max values, 00 - FF - 1 = 00 with borrow
    valid_i = 1'b1; op_i = 4'd6; acc_i = 8'h00; opnd_i = 8'hFF; stat_i = 8'h00;
    @(negedge clk);
    check("R2", "res wrap", res_o, 8'h00);
    check("R2", "stat wrap", stat_o, 8'h02);

    // R3 corner: equal compare of X with V clear gives C and Z
    op_i = 4'd8; x_i = 8'hFF; opnd_i = 8'hFF; stat_i = 8'h00;
    @(negedge clk);
    check("R3", "cpx equal stat", stat_o, 8'h03);

    // R12: asynchronous reset mid-run clears outputs at once
    valid_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R12", "async res", res_o, 8'h00);
    check("R12", "async stat", stat_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule